// File: doc/BRIEF.md
# Zero-Cross Gain Change Controller

This block changes the gain or mute setting of one audio amplifier without an audible click. One instance serves each amplifier. When the requested setting differs from the applied setting, the block raises a clock request and starts counting millisecond ticks from the request.

A change that cannot click is applied on the next cycle. A change that can click turns on an output zero-cross comparator. The block lets the comparator settle for a set number of ticks. It then commits the new setting on the first cycle in which it sees a zero crossing. If no crossing arrives before the timeout, the change is committed anyway.

After a commit, the comparator enable and the clock request both drop, and the block waits in a zero-power idle state. A muted status follows the applied mute state, so a power sequencer can use it to confirm that a mute has taken effect.

Top module: `zc_gain_ctrl`

## Requirements
- R1: Reset state: `app_gain` = `RST_GAIN` (default 0), `app_mute` = 1, `muted` = 1, `cmp_en` = 0, `clk_req` = 0, `done` = 0.
- R2: While the requested gain and mute equal the applied ones, `clk_req` and `cmp_en` stay low.
- R3: One clock edge after the requested setting first differs from the applied one, `clk_req` goes high.
- R4: A safe change commits on the second clock edge after the request, and `cmp_en` never goes high. A change is safe when mute is unchanged and the gain moves by at most `MAX_SAFE_STEP` (default 1) in either direction.
- R5: A risky change raises `cmp_en` on the second clock edge after the request. A change is risky when the mute state toggles or the gain moves by more than `MAX_SAFE_STEP`.
- R6: Comparator activity is ignored until `SETTLE_MS` (default 1) ticks have been counted since the request.
- R7: Once settling is over, the change commits on the third clock edge after `zc_raw` changes level. Two of those edges are synchronizer stages and one is the commit register. A zero crossing is any change of the synchronized level.
- R8: On the commit edge, `cmp_en` and `clk_req` go low and `done` goes high. `done` stays high for exactly one cycle.
- R9: If no crossing is seen, the change commits on the clock edge after the edge that counts the `TIMEOUT_MS`-th (default 11) tick since the request.
- R10: A new request that arrives while a change is pending replaces the target, and the timeout count is not restarted.
- R11: `muted` always equals the applied mute state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse about every millisecond |
| req_gain | input | GAIN_W | Requested gain code |
| req_mute | input | 1 | Requested mute (1 = muted) |
| zc_raw | input | 1 | Asynchronous zero-cross comparator output |
| app_gain | output | GAIN_W | Gain applied to the amplifier |
| app_mute | output | 1 | Mute applied to the amplifier |
| cmp_en | output | 1 | Comparator power enable |
| clk_req | output | 1 | Clock request to the timing domain |
| done | output | 1 | One-cycle pulse on each commit |
| muted | output | 1 | Status: the applied state is mute |

## Verification
The assertions assume that `tick_ms` is a single-cycle pulse and that the requested setting is synchronous to `clk`. On that basis they check that the applied setting changes only on a `done` cycle and only while a clock request was already active. They also check that a mute toggle is applied only after the comparator has been on. To stay within these assumptions, the bench drives every input on the falling edge, pulses each tick for exactly one cycle, and holds every `zc_raw` level for several cycles so that the synchronizer sees each crossing cleanly.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
    typedef enum logic [1:0] {
        ZC_IDLE   = 2'd0,
        ZC_ARM    = 2'd1,
        ZC_SETTLE = 2'd2,
        ZC_WATCH  = 2'd3
    } zc_state_e;
endpackage

// File: rtl/zc_sync_edge.sv
module zc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic evt
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= raw;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Any change of the synchronized level counts as a crossing.
    assign evt = s2_q ^ prev_q;
endmodule

// File: rtl/zc_risk.sv
module zc_risk #(
    parameter int GAIN_W        = 5,
    parameter int MAX_SAFE_STEP = 1
) (
    input  logic [GAIN_W-1:0] req_gain,
    input  logic              req_mute,
    input  logic [GAIN_W-1:0] cur_gain,
    input  logic              cur_mute,
    output logic              differs,
    output logic              risky
);
    localparam int DW = GAIN_W + 1;

    logic [DW-1:0] step_mag;

    always_comb begin
        if (req_gain >= cur_gain) begin
            step_mag = {1'b0, req_gain} - {1'b0, cur_gain};
        end else begin
            step_mag = {1'b0, cur_gain} - {1'b0, req_gain};
        end
        differs = (req_gain != cur_gain) || (req_mute != cur_mute);
        risky   = (req_mute != cur_mute) || (step_mag > DW'(MAX_SAFE_STEP));
    end
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
    import zc_gain_pkg::*;
#(
    parameter int GAIN_W        = 5,
    parameter int MAX_SAFE_STEP = 1,
    parameter int SETTLE_MS     = 1,
    parameter int TIMEOUT_MS    = 11,
    parameter int RST_GAIN      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic [GAIN_W-1:0] req_gain,
    input  logic              req_mute,
    input  logic              zc_raw,
    output logic [GAIN_W-1:0] app_gain,
    output logic              app_mute,
    output logic              cmp_en,
    output logic              clk_req,
    output logic              done,
    output logic              muted
);
    localparam int CNT_W = $clog2(TIMEOUT_MS + 1);
    localparam logic [CNT_W-1:0] SETTLE_CNT  = CNT_W'(SETTLE_MS);
    localparam logic [CNT_W-1:0] TIMEOUT_CNT = CNT_W'(TIMEOUT_MS);

    typedef struct packed {
        zc_state_e         st;
        logic [GAIN_W-1:0] gain;
        logic              mute;
        logic [CNT_W-1:0]  ms;
        logic              done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  zc_evt, differs, risky;

    zc_sync_edge u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (zc_raw),
        .evt   (zc_evt)
    );

    zc_risk #(
        .GAIN_W        (GAIN_W),
        .MAX_SAFE_STEP (MAX_SAFE_STEP)
    ) u_risk (
        .req_gain (req_gain),
        .req_mute (req_mute),
        .cur_gain (ctrl_q.gain),
        .cur_mute (ctrl_q.mute),
        .differs  (differs),
        .risky    (risky)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        if (ctrl_q.st != ZC_IDLE && tick_ms && ctrl_q.ms != TIMEOUT_CNT) begin
            ctrl_d.ms = ctrl_q.ms + 1'b1;
        end
        unique case (ctrl_q.st)
            ZC_IDLE: begin
                if (differs) begin
                    ctrl_d.st = ZC_ARM;
                    ctrl_d.ms = '0;
                end
            end
            ZC_ARM: begin
                if (risky) begin
                    ctrl_d.st = ZC_SETTLE;
                end else begin
                    ctrl_d.st   = ZC_IDLE;
                    ctrl_d.gain = req_gain;
                    ctrl_d.mute = req_mute;
                    ctrl_d.done = 1'b1;
                end
            end
            ZC_SETTLE: begin
                if (ctrl_q.ms >= TIMEOUT_CNT) begin
                    ctrl_d.st   = ZC_IDLE;
                    ctrl_d.gain = req_gain;
                    ctrl_d.mute = req_mute;
                    ctrl_d.done = 1'b1;
                end else if (ctrl_q.ms >= SETTLE_CNT) begin
                    ctrl_d.st = ZC_WATCH;
                end
            end
            ZC_WATCH: begin
                if (zc_evt || ctrl_q.ms >= TIMEOUT_CNT) begin
                    ctrl_d.st   = ZC_IDLE;
                    ctrl_d.gain = req_gain;
                    ctrl_d.mute = req_mute;
                    ctrl_d.done = 1'b1;
                end
            end
            default: ctrl_d.st = ZC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st   <= ZC_IDLE;
            ctrl_q.gain <= GAIN_W'(RST_GAIN);
            ctrl_q.mute <= 1'b1;
            ctrl_q.ms   <= '0;
            ctrl_q.done <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign app_gain = ctrl_q.gain;
    assign app_mute = ctrl_q.mute;
    assign muted    = ctrl_q.mute;
    assign done     = ctrl_q.done;
    assign clk_req  = (ctrl_q.st != ZC_IDLE);
    assign cmp_en   = (ctrl_q.st == ZC_SETTLE) || (ctrl_q.st == ZC_WATCH);
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk #(
    parameter int GAIN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GAIN_W-1:0] app_gain,
    input logic              app_mute,
    input logic              cmp_en,
    input logic              clk_req,
    input logic              done,
    input logic              muted
);
    // R2: the comparator is never powered without a clock request
    assert_cmp_needs_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> clk_req);

    // R8: commit drops the clock request and the comparator
    assert_commit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!clk_req && !cmp_en));

    // R8: done is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: the applied gain moves only after a clock request, on a done cycle
    assert_gain_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (app_gain != $past(app_gain)) |-> ($past(clk_req) && done));

    // R5: a mute toggle is applied only after the comparator was on
    assert_mute_via_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (app_mute != $past(app_mute)) |-> $past(cmp_en));

    // R11: the status follows the applied mute
    assert_muted_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        muted == app_mute);
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .app_gain (app_gain),
    .app_mute (app_mute),
    .cmp_en   (cmp_en),
    .clk_req  (clk_req),
    .done     (done),
    .muted    (muted)
);

// File: tb/zc_gain_ctrl_test.sv
`timescale 1ns/1ps
module zc_gain_ctrl_test;
    localparam int GW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_ms = 1'b0;
    logic [GW-1:0] req_gain = '0;
    logic          req_mute = 1'b1;
    logic          zc_raw = 1'b0;
    logic [GW-1:0] app_gain;
    logic          app_mute, cmp_en, clk_req, done, muted;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    zc_gain_ctrl #(.GAIN_W(GW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ms  (tick_ms),
        .req_gain (req_gain),
        .req_mute (req_mute),
        .zc_raw   (zc_raw),
        .app_gain (app_gain),
        .app_mute (app_mute),
        .cmp_en   (cmp_en),
        .clk_req  (clk_req),
        .done     (done),
        .muted    (muted)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R1 app_gain", int'(app_gain), 0);
        chk("R1 app_mute", int'(app_mute), 1);
        chk("R11 muted", int'(muted), 1);
        chk("R1 cmp_en", int'(cmp_en), 0);
        chk("R1 clk_req", int'(clk_req), 0);
        chk("R1 done", int'(done), 0);
    endtask

    task automatic t_idle;
        repeat (5) @(negedge clk);
        chk("R2 clk_req idle", int'(clk_req), 0);
        chk("R2 cmp_en idle", int'(cmp_en), 0);
    endtask

    task automatic t_unmute_zc;
        @(negedge clk) req_mute = 1'b0;
        @(negedge clk);
        chk("R3 clk_req", int'(clk_req), 1);
        chk("R5 cmp_en not yet", int'(cmp_en), 0);
        @(negedge clk);
        chk("R5 cmp_en on", int'(cmp_en), 1);
        zc_raw = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 ignored during settle", int'(app_mute), 1);
        pulse_ticks(1);
        @(negedge clk);
        @(negedge clk);
        zc_raw = 1'b0;
        @(negedge clk);
        chk("R7 edge1", int'(app_mute), 1);
        @(negedge clk);
        chk("R7 edge2", int'(app_mute), 1);
        @(negedge clk);
        chk("R7 commit", int'(app_mute), 0);
        chk("R11 muted follows", int'(muted), 0);
        chk("R8 done", int'(done), 1);
        chk("R8 cmp_en off", int'(cmp_en), 0);
        chk("R8 clk_req off", int'(clk_req), 0);
        @(negedge clk);
        chk("R8 done pulse", int'(done), 0);
    endtask

    task automatic t_safe_step(input int to, input int from);
        int saw_cmp = 0;
        @(negedge clk) req_gain = GW'(to);
        @(negedge clk);
        saw_cmp |= int'(cmp_en);
        chk("R3 clk_req safe", int'(clk_req), 1);
        chk("R4 not yet", int'(app_gain), from);
        @(negedge clk);
        saw_cmp |= int'(cmp_en);
        chk("R4 safe commit", int'(app_gain), to);
        chk("R4 done", int'(done), 1);
        chk("R4 no comparator", saw_cmp, 0);
    endtask

    task automatic t_timeout;
        @(negedge clk) req_gain = GW'(5);
        @(negedge clk);
        @(negedge clk);
        chk("R5 big step cmp_en", int'(cmp_en), 1);
        pulse_ticks(10);
        chk("R9 before timeout", int'(app_gain), 1);
        pulse_ticks(1);
        chk("R9 at count", int'(app_gain), 1);
        @(negedge clk);
        chk("R9 timeout commit", int'(app_gain), 5);
        chk("R9 done", int'(done), 1);
    endtask

    task automatic t_retarget;
        @(negedge clk) req_gain = GW'(10);
        @(negedge clk);
        @(negedge clk);
        pulse_ticks(4);
        req_gain = GW'(20);
        pulse_ticks(6);
        chk("R10 still pending", int'(app_gain), 5);
        pulse_ticks(1);
        @(negedge clk);
        chk("R10 new target no restart", int'(app_gain), 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_unmute_zc();
        t_safe_step(1, 0);
        t_timeout();
        t_retarget();
        t_safe_step(19, 20);
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule